// File: doc/BRIEF.md
# Multi-byte-per-cycle pattern matcher

This block scans a byte stream for a fixed set of patterns and takes several bytes in each clock cycle. Every byte lane has its own character decoder. Each decoder turns its byte into one bit line for every pattern character that is compared. These bit lines enter a short delay pipeline. Each time a word is accepted, the pipeline moves forward by one whole word, which is LANES character positions. Each pattern has one comparator for every lane at which it can start, so a pattern is found whatever its alignment to the word boundaries. It is also found when it spans two or more words.

The patterns and their lengths are fixed by parameters when the block is built. A pattern is reported against the word in which its first byte arrives, once enough later words have come in to hold its tail. The block then gives a hit flag per pattern and a per-pattern vector of the starting lanes that matched. Idle cycles in the input stream do not break a match that spans them.

Top module: `mbyte_matcher`

## Requirements
- R1: `in_data[7:0]` is lane 0 and holds the earliest byte of each word; lane l is `in_data[8*l+7:8*l]`. Character i of pattern p is `PATS[(p*MAX_LEN+i)*8 +: 8]`, and its length is `PAT_LENS[p*8 +: 8]`.
- R2: `out_valid` is high in the cycle after each rising edge at which `in_valid` was high, and low otherwise.
- R3: The report that follows the m-th accepted word (m counted from 0 after reset) covers patterns that start in accepted word m-(STAGES-1), with STAGES = floor((MAX_LEN+2*LANES-2)/LANES). The default build has STAGES = 3.
- R4: Bit p*LANES+o of `out_offset` is set when the stream bytes that start at lane o of the reported word equal pattern p over its whole length, including matches that cross word boundaries.
- R5: Several starting lanes of the same pattern can be flagged in one report.
- R6: `out_hit[p]` is the OR of the LANES offset bits of pattern p.
- R7: In a cycle with `out_valid` low, `out_offset` and `out_hit` are zero. Cycles without `in_valid` do not advance the pipeline, so a match that spans them is still found.
- R8: After reset, no hit is reported until STAGES words have been accepted.
- R9: Bytes of a pattern slot past its length are ignored. A pattern of length 0 never hits.
- R10: A reset in mid-stream discards all words held in the pipeline. No match is made across the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | The word on `in_data` is accepted at this edge |
| in_data | input | 8*LANES | LANES stream bytes; lane 0 is the earliest |
| out_valid | output | 1 | A report for one start word is present |
| out_hit | output | NUM_PAT | One flag per pattern that matched |
| out_offset | output | NUM_PAT*LANES | Starting lanes that matched, LANES bits per pattern |

## Verification
The sweep feeds a stream drawn from a four-letter alphabet with random idle gaps, and plants the longest pattern at each of the four lane alignments. A design that takes a lane's byte from the wrong pipeline stage would miss these matches that span words, or report them against the wrong word. A design that advanced the pipeline on idle cycles would lose matches across a gap. The single-letter pattern fires at several lanes at once, so a design that reported only one offset per pattern would be caught. A zero-length slot filled with a common letter, and padding bytes that never occur in the stream, catch a design that compares bytes past a pattern's length. A reset in mid-stream checks that no stale word can complete a match.

// File: rtl/mbyte_matcher.sv
module mbyte_matcher #(
  parameter int LANES   = 4,
  parameter int NUM_PAT = 5,
  parameter int MAX_LEN = 8,
  parameter logic [NUM_PAT*MAX_LEN*8-1:0] PATS =
    {"qqqqqqqa", "qqqqqqqa", "acbacbac", "qqqqqqab", "qqqqqcba"},
  parameter logic [NUM_PAT*8-1:0] PAT_LENS = {8'd0, 8'd1, 8'd8, 8'd2, 8'd3}
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic [8*LANES-1:0]         in_data,
  output logic                       out_valid,
  output logic [NUM_PAT-1:0]         out_hit,
  output logic [NUM_PAT*LANES-1:0]   out_offset
);
  localparam int STAGES = (MAX_LEN + 2*LANES - 2) / LANES;
  localparam int LINES  = NUM_PAT * MAX_LEN;

  logic [LANES-1:0][LINES-1:0]              dec;
  logic [STAGES-1:0][LANES-1:0][LINES-1:0]  hist;
  logic                                     v_q;
  logic [NUM_PAT*LANES-1:0]                 fire;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    for (genvar p = 0; p < NUM_PAT; p++) begin : g_pat
      localparam int LN = int'(PAT_LENS[p*8 +: 8]);
      for (genvar i = 0; i < MAX_LEN; i++) begin : g_chr
        if (i < LN) begin : g_cmp
          assign dec[l][p*MAX_LEN+i] = (in_data[l*8 +: 8] == PATS[(p*MAX_LEN+i)*8 +: 8]);
        end else if (i == 0) begin : g_off
          assign dec[l][p*MAX_LEN+i] = 1'b0;
        end else begin : g_pad
          assign dec[l][p*MAX_LEN+i] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist <= '0;
      v_q  <= 1'b0;
    end else begin
      v_q <= in_valid;
      if (in_valid) begin
        hist[0] <= dec;
        for (int s = 1; s < STAGES; s++) hist[s] <= hist[s-1];
      end
    end
  end

  for (genvar p = 0; p < NUM_PAT; p++) begin : g_cmpp
    for (genvar o = 0; o < LANES; o++) begin : g_off
      logic [MAX_LEN-1:0] m_b;
      for (genvar i = 0; i < MAX_LEN; i++) begin : g_bit
        localparam int POS = o + i;
        assign m_b[i] = hist[STAGES-1-POS/LANES][POS%LANES][p*MAX_LEN+i];
      end
      assign fire[p*LANES+o] = &m_b;
    end
    assign out_hit[p] = |out_offset[p*LANES +: LANES];
  end

  assign out_valid  = v_q;
  assign out_offset = v_q ? fire : '0;
endmodule

// File: rtl/mbyte_matcher_chk.sv
module mbyte_matcher_chk #(
  parameter int LANES   = 4,
  parameter int NUM_PAT = 5,
  parameter int MAX_LEN = 8,
  parameter logic [NUM_PAT*MAX_LEN*8-1:0] PATS = '0,
  parameter logic [NUM_PAT*8-1:0] PAT_LENS = '0
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     in_valid,
  input logic [8*LANES-1:0]       in_data,
  input logic                     out_valid,
  input logic [NUM_PAT-1:0]       out_hit,
  input logic [NUM_PAT*LANES-1:0] out_offset
);
  localparam int STAGES = (MAX_LEN + 2*LANES - 2) / LANES;

  logic [STAGES-1:0][8*LANES-1:0] raw;
  int unsigned                    cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw <= '0;
      cnt <= 0;
    end else if (in_valid) begin
      raw[0] <= in_data;
      for (int s = 1; s < STAGES; s++) raw[s] <= raw[s-1];
      if (cnt < STAGES) cnt <= cnt + 1;
    end
  end

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_quiet_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (out_offset == '0));
  p_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt < STAGES) |-> (out_offset == '0));

  for (genvar p = 0; p < NUM_PAT; p++) begin : g_p
    localparam int LN = int'(PAT_LENS[p*8 +: 8]);
    if (LN == 0) begin : g_dis
      p_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_hit[p]);
    end else begin : g_en
      for (genvar o = 0; o < LANES; o++) begin : g_o
        p_first_char_r4: assert property (@(posedge clk) disable iff (!rst_n)
          (out_hit[p] && out_offset[p*LANES+o]) |->
            (raw[STAGES-1][o*8 +: 8] == PATS[(p*MAX_LEN)*8 +: 8]));
      end
    end
  end
endmodule

bind mbyte_matcher mbyte_matcher_chk #(
  .LANES(LANES), .NUM_PAT(NUM_PAT), .MAX_LEN(MAX_LEN),
  .PATS(PATS), .PAT_LENS(PAT_LENS)
) u_chk (.*);

// File: tb/sim_mbyte_matcher.sv
module sim_mbyte_matcher;
  localparam int CLK_PERIOD = 10;
  localparam int LANES   = 4;
  localparam int NUM_PAT = 5;
  localparam int MAX_LEN = 8;
  localparam logic [NUM_PAT*MAX_LEN*8-1:0] PATS =
    {"qqqqqqqa", "qqqqqqqa", "acbacbac", "qqqqqqab", "qqqqqcba"};
  localparam logic [NUM_PAT*8-1:0] LENS = {8'd0, 8'd1, 8'd8, 8'd2, 8'd3};
  localparam int STAGES = (MAX_LEN + 2*LANES - 2) / LANES;  // R3: 3 here
  localparam int NW = 200;

  logic clk = 1'b0;
  logic rst_n, in_valid, out_valid;
  logic [8*LANES-1:0] in_data;
  logic [NUM_PAT-1:0] out_hit;
  logic [NUM_PAT*LANES-1:0] out_offset;

  logic [7:0] stream [NW*LANES];
  int checks = 0, fails = 0, m = 0, base = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbyte_matcher #(.LANES(LANES), .NUM_PAT(NUM_PAT), .MAX_LEN(MAX_LEN),
                  .PATS(PATS), .PAT_LENS(LENS)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_hit(out_hit), .out_offset(out_offset));

  function automatic logic [7:0] pchr(int p, int i);
    return PATS[(p*MAX_LEN+i)*8 +: 8];
  endfunction

  function automatic int plen(int p);
    return int'(LENS[p*8 +: 8]);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic beat(input logic v, input int word);
    int w;
    string tag;
    logic [LANES-1:0] e;
    bit ok;
    in_valid = v;
    for (int l = 0; l < LANES; l++)  // R1: lane 0 in the low byte, earliest
      in_data[l*8 +: 8] = v ? stream[word*LANES+l] : 8'h00;
    @(posedge clk);
    @(negedge clk);
    chk("R2 out_valid", {31'd0, out_valid}, {31'd0, v});
    if (!v) begin
      chk("R7 offsets on idle cycle", 32'(out_offset), 32'd0);
      chk("R7 hits on idle cycle", 32'(out_hit), 32'd0);
    end else begin
      w = m - (STAGES - 1);  // R3: reported start word
      m++;
      for (int p = 0; p < NUM_PAT; p++) begin
        e = '0;
        for (int o = 0; o < LANES; o++) begin
          if (w >= 0 && plen(p) > 0) begin
            ok = 1;
            for (int i = 0; i < plen(p); i++)
              if (stream[(base+w)*LANES+o+i] !== pchr(p, i)) ok = 0;
            e[o] = ok;
          end
        end
        if (w < 0) tag = (base > 0) ? "R10 refill after reset" : "R8 initial fill";
        else if (plen(p) == 0) tag = "R9 zero-length pattern";
        else if ($countones(e) > 1) tag = "R5 several offsets";
        else tag = "R4 offsets";
        chk($sformatf("%s p%0d", tag, p), 32'(out_offset[p*LANES +: LANES]), 32'(e));
        chk($sformatf("R6 hit p%0d", p), {31'd0, out_hit[p]}, {31'd0, |e});
      end
    end
  endtask

  task automatic plant(input int pos);
    for (int i = 0; i < 8; i++) stream[pos+i] = pchr(2, i);
  endtask

  task automatic run_words(input int first, input int last);
    for (int wd = first; wd <= last; wd++) begin
      while ($urandom % 4 == 0) beat(1'b0, 0);
      beat(1'b1, wd);
    end
  endtask

  initial begin
    for (int b = 0; b < NW*LANES; b++) begin
      case ($urandom % 4)
        0: stream[b] = "a";
        1: stream[b] = "b";
        2: stream[b] = "c";
        default: stream[b] = "x";
      endcase
    end
    plant(41); plant(54); plant(67); plant(80);
    plant(441); plant(458); plant(475); plant(492);

    rst_n = 0; in_valid = 0; in_data = '0;
    repeat (3) @(negedge clk);
    chk("R8 reset out_valid", {31'd0, out_valid}, 32'd0);
    chk("R8 reset offsets", 32'(out_offset), 32'd0);
    rst_n = 1;
    m = 0; base = 0;
    run_words(0, 99);

    rst_n = 0; in_valid = 0;
    @(posedge clk);
    @(negedge clk);
    chk("R10 out_valid in reset", {31'd0, out_valid}, 32'd0);
    chk("R10 offsets in reset", 32'(out_offset), 32'd0);
    rst_n = 1;
    m = 0; base = 100;
    run_words(100, NW-1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule